// File: doc/BRIEF.md
# Dual-CAS DRAM Cycle-Type Decoder

This block sits on the device side of an extended-data-out DRAM interface. It watches the row strobe, two byte-lane column strobes, the write enable and the output enable, all active low, and samples them on a fast system clock. From these strobes it works out what kind of memory cycle the controller is running. It also produces, for each byte lane, a registered output-drive enable and a registered write strobe that a memory array model or data-path steering logic can use.

The two column strobes are merged into one combined column strobe. It becomes active when the first lane strobe goes low and inactive only when the last lane strobe goes high. A row-strobe fall taken while the combined strobe is already active is a refresh cycle. That cycle uses an internal row counter and then advances it. Any other row-strobe fall opens a row at the external address. Within an open row, each combined column fall is classed as a read or an early write, depending on the write enable at that moment. A read becomes a late write if the write enable falls while output enable is high. After a lane's column strobe rises, that lane keeps driving its read data until the next combined column fall.

The controller has seven states. `S_IDLE` moves to `S_CBR` on a row fall with a column strobe low, and to `S_ROW_OPEN` on a row fall with both high. `S_ROW_OPEN` and `S_PAGE_GAP` move on a column fall to `S_COL_EWR` if write enable is low, or to `S_COL_READ` if it is high. `S_COL_READ` moves to `S_COL_LWR` on a write-enable fall with output enable high. Every column state moves to `S_PAGE_GAP` on a combined column rise. A row rise returns every state to `S_IDLE`, and it takes priority over other events.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The combined column strobe goes active on the first lane-strobe fall and inactive only on the last lane-strobe rise. A second lane falling, or one lane rising and falling again, while the other lane stays low does not start a new column cycle.
- R2: A row fall while any column strobe is low emits code 4 (refresh). The active row takes the counter's value, the counter steps by one (modulo 2^ROW_W), and both lanes neither drive nor write.
- R3: A row fall while both column strobes are high captures the external row address as the active row.
- R4: A column fall with write enable already low emits code 2 (early write). Each lane whose strobe is low asserts its write strobe, and no lane drives.
- R5: During a read, a write-enable fall with output enable high emits code 3 (late write). The write strobes of the low lanes assert, and no lane drives.
- R6: In a read cycle, a lane drives only while row strobe, its own column strobe and output enable are low and write enable is high. Taking output enable high stops the drive.
- R7: After its column strobe rises, a lane keeps driving until the next combined column fall, until row and both column strobes are high, or until output enable goes high or write enable goes low.
- R8: A row rise with no column cycle since the row fall emits code 5 (row-only refresh). When the row strobe and both column strobes are high, both lanes stop driving.
- R9: A resolved cycle-type code (1 read, 2 early write, 3 late write, 4 refresh, 5 row-only refresh) shows for one clock only, three clocks after the strobe change. At all other times the code is 0.
- R10: After reset the code is 0, no lane drives or writes, and the active row and the refresh counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, bit 0 low byte, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_addr | input | ROW_W | External row address |
| cycle_code | output | 3 | One-clock cycle-type code, 0 when none |
| lane_drive | output | LANES | Per-lane output-drive enable |
| lane_write | output | LANES | Per-lane write strobe |
| active_row | output | ROW_W | Row used by the current cycle |
| refresh_row | output | ROW_W | Internal refresh counter value |

## Verification
Every result appears three clocks after the strobe change that causes it: two clocks for the synchronizer and one for the registered output. The code pulse, the lane drive and write flags, and the row and counter values all follow this timing. The bench drives inputs on a falling clock edge and reads results on the third falling edge after that. One more falling edge later it confirms that the code has gone back to 0. Each scenario lets the strobes settle for three clocks before the next scenario starts.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [2:0] {
        CY_NONE    = 3'd0,
        CY_READ    = 3'd1,
        CY_EWRITE  = 3'd2,
        CY_LWRITE  = 3'd3,
        CY_CBR     = 3'd4,
        CY_RASONLY = 3'd5
    } cyc_code_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW_OPEN,
        S_COL_READ,
        S_COL_EWR,
        S_COL_LWR,
        S_PAGE_GAP,
        S_CBR
    } fsm_state_t;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_ONE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_VAL = {W{RST_ONE}};

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[i] <= RST_VAL;
                end else if (i == 0) begin
                    stg[i] <= d;
                end else begin
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
    import dcd_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic             cas_fall,
    input  logic             cas_rise,
    input  logic             cas_any_low,
    input  logic             we_low,
    input  logic             we_fall,
    input  logic             oe_high,
    input  logic [ROW_W-1:0] row_ext,
    output fsm_state_t       state_n,
    output cyc_code_t        code_q,
    output logic [ROW_W-1:0] active_row,
    output logic [ROW_W-1:0] refresh_row
);
    fsm_state_t state_q;
    cyc_code_t  code_d;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (ras_fall) state_n = cas_any_low ? S_CBR : S_ROW_OPEN;
            end
            S_ROW_OPEN, S_PAGE_GAP: begin
                if (ras_rise)      state_n = S_IDLE;
                else if (cas_fall) state_n = we_low ? S_COL_EWR : S_COL_READ;
            end
            S_COL_READ: begin
                if (ras_rise)                state_n = S_IDLE;
                else if (cas_rise)           state_n = S_PAGE_GAP;
                else if (we_fall && oe_high) state_n = S_COL_LWR;
            end
            S_COL_EWR, S_COL_LWR: begin
                if (ras_rise)      state_n = S_IDLE;
                else if (cas_rise) state_n = S_PAGE_GAP;
            end
            S_CBR: begin
                if (ras_rise) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_comb begin
        code_d = CY_NONE;
        if (state_n != state_q) begin
            unique case (state_n)
                S_CBR:      code_d = CY_CBR;
                S_COL_READ: code_d = CY_READ;
                S_COL_EWR:  code_d = CY_EWRITE;
                S_COL_LWR:  code_d = CY_LWRITE;
                S_IDLE:     code_d = (state_q == S_ROW_OPEN) ? CY_RASONLY : CY_NONE;
                default:    code_d = CY_NONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q      <= CY_NONE;
            active_row  <= '0;
            refresh_row <= '0;
        end else begin
            code_q <= code_d;
            if (state_q == S_IDLE && state_n == S_CBR) begin
                active_row  <= refresh_row;
                refresh_row <= refresh_row + 1'b1;
            end else if (state_q == S_IDLE && state_n == S_ROW_OPEN) begin
                active_row <= row_ext;
            end
        end
    end
endmodule

// File: rtl/dcd_lane.sv
module dcd_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic cas_low,
    input  logic any_cas_fall,
    input  logic all_high,
    input  logic oe_low,
    input  logic we_high,
    input  logic nxt_read,
    input  logic nxt_write,
    input  logic nxt_cbr,
    output logic drive,
    output logic wstrb
);
    logic read_on;
    logic hold_on;

    assign read_on = nxt_read && cas_low && oe_low && we_high;
    assign hold_on = drive && oe_low && we_high && !any_cas_fall && !all_high && !nxt_cbr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
            wstrb <= 1'b0;
        end else begin
            drive <= read_on || hold_on;
            wstrb <= nxt_write && cas_low;
        end
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] row_addr,
    output logic [2:0]       cycle_code,
    output logic [LANES-1:0] lane_drive,
    output logic [LANES-1:0] lane_write,
    output logic [ROW_W-1:0] active_row,
    output logic [ROW_W-1:0] refresh_row
);
    localparam int SW    = LANES + 3;
    localparam int I_RAS = LANES;
    localparam int I_WE  = LANES + 1;
    localparam int I_OE  = LANES + 2;

    logic [SW-1:0]    strb_s;
    logic [SW-1:0]    strb_p;
    logic [ROW_W-1:0] row_s;

    dcd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, ras_n, cas_n}), .q(strb_s)
    );

    dcd_sync #(.W(ROW_W), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_sync_row (
        .clk(clk), .rst_n(rst_n), .d(row_addr), .q(row_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_p <= '1;
        else        strb_p <= strb_s;
    end

    logic cas_any_low, cas_any_low_p;
    logic cas_fall, cas_rise, ras_fall, ras_rise, we_fall, all_high;

    assign cas_any_low   = ~&strb_s[LANES-1:0];
    assign cas_any_low_p = ~&strb_p[LANES-1:0];
    assign cas_fall      = cas_any_low && !cas_any_low_p;
    assign cas_rise      = !cas_any_low && cas_any_low_p;
    assign ras_fall      = !strb_s[I_RAS] && strb_p[I_RAS];
    assign ras_rise      = strb_s[I_RAS] && !strb_p[I_RAS];
    assign we_fall       = !strb_s[I_WE] && strb_p[I_WE];
    assign all_high      = strb_s[I_RAS] && !cas_any_low;

    fsm_state_t state_n;
    cyc_code_t  code_q;

    dcd_cycle_fsm #(.ROW_W(ROW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise),
        .cas_any_low(cas_any_low),
        .we_low(!strb_s[I_WE]), .we_fall(we_fall),
        .oe_high(strb_s[I_OE]),
        .row_ext(row_s),
        .state_n(state_n), .code_q(code_q),
        .active_row(active_row), .refresh_row(refresh_row)
    );

    assign cycle_code = code_q;

    logic nxt_read, nxt_write, nxt_cbr;
    assign nxt_read  = (state_n == S_COL_READ);
    assign nxt_write = (state_n == S_COL_EWR) || (state_n == S_COL_LWR);
    assign nxt_cbr   = (state_n == S_CBR);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dcd_lane u_lane (
                .clk(clk), .rst_n(rst_n),
                .cas_low(!strb_s[g]),
                .any_cas_fall(cas_fall),
                .all_high(all_high),
                .oe_low(!strb_s[I_OE]),
                .we_high(strb_s[I_WE]),
                .nxt_read(nxt_read), .nxt_write(nxt_write), .nxt_cbr(nxt_cbr),
                .drive(lane_drive[g]), .wstrb(lane_write[g])
            );
        end
    endgenerate
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int ROW_W = 12,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cycle_code,
    input logic [LANES-1:0] lane_drive,
    input logic [LANES-1:0] lane_write,
    input logic [ROW_W-1:0] refresh_row
);
    // R2: refresh cycle leaves both lanes idle
    a_r2_cbr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_code == 3'd4) |-> (lane_drive == '0 && lane_write == '0));

    // R2: counter steps by one when a refresh is decoded
    a_r2_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_code == 3'd4) |-> (refresh_row == $past(refresh_row) + 1'b1));

    // R4: early write never drives
    a_r4_ewr_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_code == 3'd2) |-> (lane_drive == '0));

    // R5: late write never drives
    a_r5_lwr_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_code == 3'd3) |-> (lane_drive == '0));

    // R6: a lane never drives and writes together
    a_r6_lane_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_drive & lane_write) == '0);

    // R9: a code does not repeat on the next clock
    a_r9_code_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_code != 3'd0) |=> (cycle_code != $past(cycle_code)));
endmodule

bind dram_cycle_decoder dcd_checker #(.ROW_W(ROW_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cycle_code(cycle_code),
    .lane_drive(lane_drive), .lane_write(lane_write), .refresh_row(refresh_row)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    localparam int ROW_W = 12;
    localparam int LANES = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ras_n = 1'b1;
    logic [LANES-1:0] cas_n = '1;
    logic             we_n = 1'b1;
    logic             oe_n = 1'b1;
    logic [ROW_W-1:0] row_addr = '0;
    logic [2:0]       cycle_code;
    logic [LANES-1:0] lane_drive;
    logic [LANES-1:0] lane_write;
    logic [ROW_W-1:0] active_row;
    logic [ROW_W-1:0] refresh_row;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_decoder #(.ROW_W(ROW_W), .LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .row_addr(row_addr),
        .cycle_code(cycle_code), .lane_drive(lane_drive), .lane_write(lane_write),
        .active_row(active_row), .refresh_row(refresh_row)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    task automatic end_cycle();
        ras_n = 1'b1; cas_n = '1; we_n = 1'b1; oe_n = 1'b1;
        wait3();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10", "code", 32'(cycle_code), 0);
        chk("R10", "drive", 32'(lane_drive), 0);
        chk("R10", "write", 32'(lane_write), 0);
        chk("R10", "active_row", 32'(active_row), 0);
        chk("R10", "refresh_row", 32'(refresh_row), 0);
    endtask

    task automatic t_read_word();
        row_addr = 12'h5A3; ras_n = 1'b0;
        wait3();
        chk("R3", "active_row", 32'(active_row), 32'h5A3);
        chk("R9", "no code on activation", 32'(cycle_code), 0);
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b00;
        wait3();
        chk("R9", "read code", 32'(cycle_code), 1);
        chk("R6", "word drive", 32'(lane_drive), 3);
        @(negedge clk);
        chk("R9", "pulse ends", 32'(cycle_code), 0);
        oe_n = 1'b1;
        wait3();
        chk("R6", "oe high stops drive", 32'(lane_drive), 0);
        oe_n = 1'b0;
        wait3();
        chk("R6", "oe low drives again", 32'(lane_drive), 3);
        ras_n = 1'b1; cas_n = 2'b11;
        wait3();
        chk("R8", "end clears drive", 32'(lane_drive), 0);
        chk("R8", "no row-only code after column", 32'(cycle_code), 0);
        end_cycle();
    endtask

    task automatic t_byte_read();
        ras_n = 1'b0;
        wait3();
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b01;
        wait3();
        chk("R6", "upper byte read code", 32'(cycle_code), 1);
        chk("R6", "upper lane only", 32'(lane_drive), 2);
        end_cycle();
    endtask

    task automatic t_edo_hold();
        ras_n = 1'b0;
        wait3();
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b00;
        wait3();
        cas_n = 2'b11;
        wait3();
        chk("R7", "hold after column rise", 32'(lane_drive), 3);
        we_n = 1'b0; cas_n = 2'b00;
        wait3();
        chk("R4", "page early write code", 32'(cycle_code), 2);
        chk("R7", "hold ends at column fall", 32'(lane_drive), 0);
        chk("R4", "write both lanes", 32'(lane_write), 3);
        end_cycle();
        chk("R4", "write strobe cleared", 32'(lane_write), 0);
        ras_n = 1'b0;
        wait3();
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b00;
        wait3();
        cas_n = 2'b11;
        wait3();
        chk("R7", "hold in gap", 32'(lane_drive), 3);
        ras_n = 1'b1;
        wait3();
        chk("R7", "hold ends at row end", 32'(lane_drive), 0);
        end_cycle();
    endtask

    task automatic t_early_byte_write();
        ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        wait3();
        cas_n = 2'b10;
        wait3();
        chk("R4", "early write code", 32'(cycle_code), 2);
        chk("R4", "lower lane write", 32'(lane_write), 1);
        chk("R4", "no drive", 32'(lane_drive), 0);
        end_cycle();
    endtask

    task automatic t_late_write();
        ras_n = 1'b0;
        wait3();
        we_n = 1'b1; oe_n = 1'b1; cas_n = 2'b00;
        wait3();
        chk("R5", "read before late write", 32'(cycle_code), 1);
        we_n = 1'b0;
        wait3();
        chk("R5", "late write code", 32'(cycle_code), 3);
        chk("R5", "late write strobes", 32'(lane_write), 3);
        chk("R5", "late write no drive", 32'(lane_drive), 0);
        end_cycle();
    endtask

    task automatic t_cbr();
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b00;
        wait3();
        ras_n = 1'b0;
        wait3();
        chk("R2", "refresh code", 32'(cycle_code), 4);
        chk("R2", "counter stepped", 32'(refresh_row), 1);
        chk("R2", "row from counter", 32'(active_row), 0);
        chk("R2", "lanes quiet", 32'(lane_drive), 0);
        end_cycle();
        cas_n = 2'b01;
        wait3();
        ras_n = 1'b0;
        wait3();
        chk("R2", "second refresh code", 32'(cycle_code), 4);
        chk("R2", "second row", 32'(active_row), 1);
        chk("R2", "counter at two", 32'(refresh_row), 2);
        end_cycle();
    endtask

    task automatic t_ras_only();
        row_addr = 12'h0F0; ras_n = 1'b0;
        wait3();
        ras_n = 1'b1;
        wait3();
        chk("R8", "row-only code", 32'(cycle_code), 5);
        chk("R8", "row-only active row", 32'(active_row), 32'h0F0);
        chk("R8", "counter untouched", 32'(refresh_row), 2);
        end_cycle();
    endtask

    task automatic t_combined_cas();
        ras_n = 1'b0;
        wait3();
        we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b10;
        wait3();
        chk("R1", "first lane fall reads", 32'(cycle_code), 1);
        chk("R1", "lower lane drives", 32'(lane_drive), 1);
        cas_n = 2'b00;
        wait3();
        chk("R1", "second fall no code", 32'(cycle_code), 0);
        chk("R1", "both lanes drive", 32'(lane_drive), 3);
        cas_n = 2'b01;
        wait3();
        chk("R1", "one rise no code", 32'(cycle_code), 0);
        cas_n = 2'b00;
        wait3();
        chk("R1", "refall no new cycle", 32'(cycle_code), 0);
        end_cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_read_word();
        t_byte_read();
        t_edo_hold();
        t_early_byte_write();
        t_late_write();
        t_cbr();
        t_ras_only();
        t_combined_cas();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule